// File: doc/BRIEF.md
# Command-Sequence Write Unlock Gate

This block sits in front of a page-write controller for a non-volatile array and decides, write by write, whether a byte may be committed. Every write operation must open with three command writes, each matching a parameterized address/data pair in order. The command bytes are consumed here and are never passed on as storable data. Once the third command matches, the gate opens and every further write in the same load window is granted. When the load window closes, the gate locks again, so the next operation must repeat the unlock.

The load window is timed by a shared timeout tick. Every accepted write restarts the count. When `WIN_TICKS` ticks pass with no write, the window closes and a one-cycle `win_close` pulse tells the controller that internal programming begins. Any write that arrives without a complete unlock still opens a window. That window ends in a `win_close` pulse, so the programming timer runs, but every write in it is discarded.

Writes enter on a valid/ready channel. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. Each accepted write yields exactly one decision on the output channel, which echoes the write's address and data with a grant or a discard flag. The output is a single register stage. `wr_ready` is low only while a decision is held and `dec_ready` is low, and a held decision stays unchanged until it is taken.

Top module: `sdp_unlock_seq`

## Requirements
- R1: After reset the gate is locked: `unlocked`=0, `dec_valid`=0, `win_close`=0 and `wr_ready`=1.
- R2: Writes of 0x5555/0xAA, 0x2AAA/0x55 and 0x5555/0xA0, in that order and within one load window, set `unlocked`. Every later write in that window is decided with `dec_grant`=1 and `dec_discard`=0.
- R3: Each of the three command writes is decided with `dec_discard`=1 and `dec_grant`=0. After unlock, a write to a command address with any data, including a command data value, is granted like any other location.
- R4: A write accepted while locked that does not match the first command pair is discarded. It still opens a load window that ends in a `win_close` pulse.
- R5: A write that does not match the expected step, at any step, is discarded and aborts the sequence. Every write until that window closes is discarded, even a correct command sequence. After the window closes, the sequence starts again from its first step.
- R6: The window closes on the `WIN_TICKS`-th tick (default 4) counted after the last accepted write. With `WIN_TICKS`-1 ticks between writes, a sequence or data load continues. A window that closes partway through the sequence loses it, and the next write is judged as a first step.
- R7: When the load window closes, `win_close` is high for the cycle after the expiring tick's edge, and `unlocked` returns to 0 in that same cycle. The next write is discarded unless it starts a new unlock.
- R8: While `dec_valid`=1 and `dec_ready`=0, `wr_ready`=0, no write is taken, and the decision's address, data and flags stay unchanged.
- R9: Each decision carries the accepted write's address and data unchanged. Exactly one of `dec_grant` and `dec_discard` is set.
- R10: `win_close` is never high for two consecutive cycles. Ticks while no window is open produce no pulse.
- R11: A write accepted in the same cycle as the tick that would close the window keeps the window open and is judged in the open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe presented |
| wr_ready | output | 1 | Gate can take a write this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| load_tick | input | 1 | One-cycle timeout tick shared with the page controller |
| dec_valid | output | 1 | Decision available |
| dec_ready | input | 1 | Controller takes the decision |
| dec_addr | output | AW | Address of the decided write |
| dec_data | output | DW | Data of the decided write |
| dec_grant | output | 1 | Write may be committed to the array |
| dec_discard | output | 1 | Write must not be stored |
| win_close | output | 1 | One-cycle pulse: load window ended, programming starts |
| unlocked | output | 1 | Current window was opened by a full command sequence |

## Verification
The bench checks that a wrong middle command poisons the rest of its window. A design that only rewinds to the first step would let a correct sequence unlock straight after the mismatch. The bench also tests the tick count at its boundary, one tick short of and exactly at the limit, and a write landing on the expiring tick. An off-by-one counter would close too early or too late, and a wrong priority would drop a granted byte. Finally, the bench writes command addresses and command data after unlock, and stalls the output channel with a second write pending. A design that treats every command pattern as a command would discard real data, and a broken stall would overwrite the held decision.

// File: rtl/sdp_unlock_pkg.sv
package sdp_unlock_pkg;
  localparam int CMD_STEPS = 3;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_SEQ    = 2'd1,
    M_OPEN   = 2'd2,
    M_REJECT = 2'd3
  } gate_mode_e;
endpackage

// File: rtl/sdp_cmd_match.sv
module sdp_cmd_match #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int STEPS = 3,
  parameter logic [STEPS-1:0][AW-1:0] CMD_ADDR = '0,
  parameter logic [STEPS-1:0][DW-1:0] CMD_DATA = '0
) (
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  output logic [STEPS-1:0] hit
);
  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign hit[k] = (addr == CMD_ADDR[k]) && (data == CMD_DATA[k]);
  end
endmodule

// File: rtl/sdp_load_window.sv
module sdp_load_window #(
  parameter int WIN_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt;

  assign expire = active && tick && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || expire || !active) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: window count never runs beyond its limit while open
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/sdp_unlock_seq.sv
module sdp_unlock_seq
  import sdp_unlock_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int WIN_TICKS = 4,
  parameter logic [CMD_STEPS-1:0][AW-1:0] CMD_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [CMD_STEPS-1:0][DW-1:0] CMD_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_tick,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [AW-1:0] dec_addr,
  output logic [DW-1:0] dec_data,
  output logic          dec_grant,
  output logic          dec_discard,
  output logic          win_close,
  output logic          unlocked
);
  localparam int IW = (CMD_STEPS > 1) ? $clog2(CMD_STEPS) : 1;
  localparam logic [IW-1:0] LAST_STEP = IW'(CMD_STEPS - 1);

  gate_mode_e          mode, mode_nx;
  logic [IW-1:0]       step, step_nx;
  logic [CMD_STEPS-1:0] hit;
  logic                sel_hit;
  logic                acc;
  logic                grant_nx;
  logic                expire;

  assign acc      = wr_valid && wr_ready;
  assign wr_ready = !dec_valid || dec_ready;
  assign unlocked = (mode == M_OPEN);

  sdp_cmd_match #(
    .AW(AW), .DW(DW), .STEPS(CMD_STEPS),
    .CMD_ADDR(CMD_ADDR), .CMD_DATA(CMD_DATA)
  ) u_match (
    .addr(wr_addr),
    .data(wr_data),
    .hit (hit)
  );

  sdp_load_window #(.WIN_TICKS(WIN_TICKS)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (mode != M_IDLE),
    .restart(acc),
    .tick   (load_tick),
    .expire (expire)
  );

  always_comb begin
    sel_hit = 1'b0;
    for (int k = 0; k < CMD_STEPS; k++) begin
      if (step == IW'(k)) sel_hit = hit[k];
    end
  end

  always_comb begin
    mode_nx  = mode;
    step_nx  = step;
    grant_nx = 1'b0;
    if (acc) begin
      unique case (mode)
        M_IDLE, M_SEQ: begin
          if (sel_hit) begin
            if (step == LAST_STEP) begin
              mode_nx = M_OPEN;
              step_nx = '0;
            end else begin
              mode_nx = M_SEQ;
              step_nx = step + 1'b1;
            end
          end else begin
            mode_nx = M_REJECT;
            step_nx = '0;
          end
        end
        M_OPEN:   grant_nx = 1'b1;
        M_REJECT: grant_nx = 1'b0;
        default:  grant_nx = 1'b0;
      endcase
    end else if (expire) begin
      mode_nx = M_IDLE;
      step_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_IDLE;
      step      <= '0;
      win_close <= 1'b0;
    end else begin
      mode      <= mode_nx;
      step      <= step_nx;
      win_close <= expire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_addr    <= '0;
      dec_data    <= '0;
      dec_grant   <= 1'b0;
      dec_discard <= 1'b0;
    end else if (acc) begin
      dec_valid   <= 1'b1;
      dec_addr    <= wr_addr;
      dec_data    <= wr_data;
      dec_grant   <= grant_nx;
      dec_discard <= !grant_nx;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  // R2: a write taken while locked can never be granted
  a_r2_locked_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !unlocked) |=> (dec_valid && dec_discard && !dec_grant));

  // R8: a stalled decision holds its contents
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_addr) && $stable(dec_data)
                                   && $stable(dec_grant) && $stable(dec_discard)));

  // R10: the close pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> !win_close);

  // R7: closing the window relocks the gate
  a_r7_close_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |-> !unlocked);

  // R11: a write never coincides with a close of its own window
  a_r11_write_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !win_close);
endmodule

// File: tb/sdp_unlock_seq_bench.sv
module sdp_unlock_seq_bench;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int WT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          load_tick = 1'b0;
  logic          dec_valid;
  logic          dec_ready = 1'b1;
  logic [AW-1:0] dec_addr;
  logic [DW-1:0] dec_data;
  logic          dec_grant;
  logic          dec_discard;
  logic          win_close;
  logic          unlocked;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sdp_unlock_seq u_sdp_unlock_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_tick(load_tick),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_addr(dec_addr), .dec_data(dec_data),
    .dec_grant(dec_grant), .dec_discard(dec_discard),
    .win_close(win_close), .unlocked(unlocked)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write, returns after its decision is visible
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic exp_grant, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(dec_valid === 1'b1, {tag, " R9 valid"}, 32'(dec_valid), 1);
    chk(dec_grant === exp_grant, {tag, " grant"}, 32'(dec_grant), 32'(exp_grant));
    chk(dec_discard === !exp_grant, {tag, " R9 discard"}, 32'(dec_discard), 32'(!exp_grant));
    chk(dec_addr === a && dec_data === d, {tag, " R9 echo"}, {9'd0, dec_addr, dec_data}, {9'd0, a, d});
  endtask

  // n ticks; returns with the result of the last one visible
  task automatic ticks(input int n, input logic exp_close, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); load_tick = 1'b1;
      @(negedge clk); load_tick = 1'b0;
      if (i < n - 1) chk(win_close === 1'b0, {tag, " early close"}, 32'(win_close), 0);
    end
    chk(win_close === exp_close, {tag, " close"}, 32'(win_close), 32'(exp_close));
    if (exp_close) begin
      chk(unlocked === 1'b0, {tag, " R7 relock"}, 32'(unlocked), 0);
      @(negedge clk);
      chk(win_close === 1'b0, {tag, " R10 one cycle"}, 32'(win_close), 0);
    end
  endtask

  task automatic unlock(input string tag);
    wr(15'h5555, 8'hAA, 1'b0, {tag, " R3 cmd1"});
    wr(15'h2AAA, 8'h55, 1'b0, {tag, " R3 cmd2"});
    wr(15'h5555, 8'hA0, 1'b0, {tag, " R3 cmd3"});
  endtask

  task automatic t_reset();
    chk(unlocked === 1'b0 && dec_valid === 1'b0 && win_close === 1'b0 && wr_ready === 1'b1,
        "R1 reset state", {28'd0, unlocked, dec_valid, win_close, wr_ready}, 32'h1);
  endtask

  task automatic t_unlock_load();
    unlock("unlock");
    chk(unlocked === 1'b1, "R2 unlocked", 32'(unlocked), 1);
    wr(15'h5555, 8'hAA, 1'b1, "R3 cmd addr usable");
    wr(15'h0123, 8'h3C, 1'b1, "R2 data grant");
    ticks(WT - 1, 1'b0, "R6 short gap");
    wr(15'h2AAA, 8'h55, 1'b1, "R6 load continues");
    ticks(WT, 1'b1, "R7 window end");
    wr(15'h0040, 8'h11, 1'b0, "R7 after close");
    ticks(WT, 1'b1, "R4 reject window");
  endtask

  task automatic t_no_unlock();
    wr(15'h1000, 8'h77, 1'b0, "R4 plain write");
    chk(unlocked === 1'b0, "R4 still locked", 32'(unlocked), 0);
    ticks(WT, 1'b1, "R4 timer runs");
    ticks(WT, 1'b0, "R10 idle ticks");
  endtask

  task automatic t_mismatch();
    wr(15'h5555, 8'hAA, 1'b0, "R5 cmd1");
    wr(15'h2AAA, 8'h56, 1'b0, "R5 bad cmd2");
    unlock("R5 poisoned");
    chk(unlocked === 1'b0, "R5 stays locked", 32'(unlocked), 0);
    wr(15'h0200, 8'h99, 1'b0, "R5 data discarded");
    ticks(WT, 1'b1, "R5 close");
    unlock("R5 retry");
    chk(unlocked === 1'b1, "R5 restart unlocks", 32'(unlocked), 1);
    wr(15'h0201, 8'h5A, 1'b1, "R5 retry grant");
    ticks(WT, 1'b1, "R5 retry close");
  endtask

  task automatic t_timeout_mid();
    wr(15'h5555, 8'hAA, 1'b0, "R6 cmd1");
    ticks(WT, 1'b1, "R6 mid timeout");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 late cmd2");
    wr(15'h5555, 8'hA0, 1'b0, "R6 late cmd3");
    chk(unlocked === 1'b0, "R6 sequence lost", 32'(unlocked), 0);
    ticks(WT, 1'b1, "R6 close lost");
    wr(15'h5555, 8'hAA, 1'b0, "R6 slow cmd1");
    ticks(WT - 1, 1'b0, "R6 gap1");
    wr(15'h2AAA, 8'h55, 1'b0, "R6 slow cmd2");
    ticks(WT - 1, 1'b0, "R6 gap2");
    wr(15'h5555, 8'hA0, 1'b0, "R6 slow cmd3");
    chk(unlocked === 1'b1, "R6 slow unlock", 32'(unlocked), 1);
    ticks(WT, 1'b1, "R6 slow close");
  endtask

  task automatic t_same_cycle();
    unlock("R11 unlock");
    ticks(WT - 1, 1'b0, "R11 pre");
    @(negedge clk);
    load_tick = 1'b1; wr_valid = 1'b1; wr_addr = 15'h0333; wr_data = 8'hE7;
    @(negedge clk);
    load_tick = 1'b0; wr_valid = 1'b0;
    chk(win_close === 1'b0, "R11 no close", 32'(win_close), 0);
    chk(dec_valid === 1'b1 && dec_grant === 1'b1, "R11 grant", {30'd0, dec_valid, dec_grant}, 3);
    chk(unlocked === 1'b1, "R11 still open", 32'(unlocked), 1);
    ticks(WT, 1'b1, "R11 close later");
  endtask

  task automatic t_backpressure();
    unlock("R8 unlock");
    @(negedge clk);
    dec_ready = 1'b0;
    wr_valid = 1'b1; wr_addr = 15'h0A0A; wr_data = 8'h12;
    @(negedge clk);
    wr_addr = 15'h0B0B; wr_data = 8'h34;
    chk(wr_ready === 1'b0, "R8 ready low", 32'(wr_ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk(dec_valid === 1'b1 && dec_addr === 15'h0A0A && dec_data === 8'h12, "R8 held",
        {9'd0, dec_addr, dec_data}, {9'd0, 15'h0A0A, 8'h12});
    dec_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(dec_valid === 1'b1 && dec_addr === 15'h0B0B && dec_data === 8'h34 && dec_grant === 1'b1,
        "R8 second taken", {9'd0, dec_addr, dec_data}, {9'd0, 15'h0B0B, 8'h34});
    @(negedge clk);
    chk(dec_valid === 1'b0, "R8 drained", 32'(dec_valid), 0);
    ticks(WT, 1'b1, "R8 close");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock_load();
    t_no_unlock();
    t_mismatch();
    t_timeout_mid();
    t_same_cycle();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule